// File: doc/BRIEF.md
# Byte-Serial Register/Memory MOV Decoder

This block sits behind an instruction byte source and turns a stream of bytes into decoded register/memory MOV records. Bytes arrive one per cycle in which `in_valid` is high; cycles with `in_valid` low carry no byte and are skipped. The first byte of an instruction carries the operation code together with a direction bit and a width bit. The second byte carries the addressing mode, a register field and a register-or-memory field. Depending on the mode, zero, one or two displacement bytes follow. The decoder therefore cannot know the length of an instruction until it has seen the second byte.

Once the last byte of an instruction has been taken, the block pulses `out_valid` for one cycle. The record on the outputs gives the source and destination operands, each one either a register code or a memory base code. It also gives the width flag, a direct-address flag, a sign-correct 16-bit displacement and the instruction length in bytes. A first byte carrying any other operation code raises `err_opcode` for one cycle instead. That byte is consumed, and the decoder waits for a fresh first byte.

Top module: `mov_byte_decoder`

## Requirements
- R1: After synchronous reset, `out_valid` and `err_opcode` are low and the next accepted byte is treated as the first byte of an instruction, even if reset cut an instruction short.
- R2: A first byte whose bits 7:2 differ from 100010 raises `err_opcode` for exactly one cycle, the cycle after it is accepted. It produces no record, and the following byte is taken as a new first byte.
- R3: Bit 1 of the first byte is the direction bit. When it is 1, the register field (second byte bits 5:3) is the destination and the register/memory operand is the source; when it is 0, the roles are swapped.
- R4: Bit 0 of the first byte is reported unchanged on `out_wide` (1 = 16-bit registers, 0 = 8-bit halves).
- R5: Mode 11 (second byte bits 7:6) makes both operands registers (`*_mem` = 0), with codes taken from bits 5:3 and 2:0. The displacement is 0 and the length is 2.
- R6: Mode 00 with register/memory code other than 110 gives a memory operand whose base code is bits 2:0. The displacement is 0, the direct flag is 0 and the length is 2.
- R7: Mode 01 takes one displacement byte, sign-extended to 16 bits, and the length is 3.
- R8: Mode 10 takes two displacement bytes, low byte first, and the length is 4.
- R9: Mode 00 with register/memory code 110 sets `out_direct`, takes a 16-bit displacement low byte first, and gives length 4.
- R10: Cycles with `in_valid` low are ignored whatever `in_byte` carries. The record appears in the cycle after the clock edge that accepts the last byte, however many idle cycles lie between the bytes.
- R11: `out_valid` and `err_opcode` each last one cycle, are never high together, and are low in every cycle that does not complete an instruction or reject a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded record valid (one-cycle pulse) |
| out_wide | output | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| out_src_mem | output | 1 | Source is memory (1) or register (0) |
| out_src_code | output | 3 | Source register code or memory base code |
| out_dst_mem | output | 1 | Destination is memory (1) or register (0) |
| out_dst_code | output | 3 | Destination register code or memory base code |
| out_direct | output | 1 | Memory operand is a direct 16-bit address |
| out_disp | output | 16 | Signed displacement or direct address |
| out_len | output | 3 | Instruction length in bytes |
| err_opcode | output | 1 | Unsupported first byte rejected (one-cycle pulse) |

## Verification
Every result is due exactly one cycle after the clock edge that accepts the byte deciding it. A record follows the last byte of an instruction, and an error pulse follows a rejected first byte. Nothing else is ever due. The reference model in the bench sees each accepted byte right after its edge and queues the outcome for the next falling edge. At every falling edge, it compares the outputs with the head of that queue, or with silence when the queue is empty. Stalls inserted between bytes therefore test that the timing follows accepted bytes rather than elapsed cycles.

// File: rtl/movdec_pkg.sv
package movdec_pkg;

    localparam int BYTE_W = 8;
    localparam int DISP_W = 2 * BYTE_W;
    localparam int LEN_W  = 3;
    localparam int CODE_W = 3;

    localparam logic [5:0]        MOV_RM_OPC = 6'b100010;
    localparam logic [1:0]        MODE_MEM0  = 2'b00;
    localparam logic [1:0]        MODE_MEM8  = 2'b01;
    localparam logic [1:0]        MODE_MEM16 = 2'b10;
    localparam logic [1:0]        MODE_REG   = 2'b11;
    localparam logic [CODE_W-1:0] RM_DIRECT  = 3'b110;
    localparam logic [LEN_W-1:0]  BASE_LEN   = 3'd2;

    typedef enum logic [1:0] {
        ST_OPC,
        ST_MODRM,
        ST_DLO,
        ST_DHI
    } dec_state_e;

    typedef enum logic {
        OPK_REG = 1'b0,
        OPK_MEM = 1'b1
    } opnd_kind_e;

    typedef struct packed {
        opnd_kind_e          kind;
        logic [CODE_W-1:0]   code;
    } opnd_t;

    typedef struct packed {
        logic                dir;
        logic                wide;
        logic [1:0]          mode;
        logic [CODE_W-1:0]   reg_f;
        logic [CODE_W-1:0]   rm_f;
    } hdr_t;

    typedef struct packed {
        opnd_t               src;
        opnd_t               dst;
        logic                wide;
        logic                direct;
        logic [DISP_W-1:0]   disp;
        logic [LEN_W-1:0]    len;
    } mov_rec_t;

    // Number of displacement bytes implied by the mode and r/m fields.
    function automatic logic [1:0] disp_bytes(input logic [1:0] mode,
                                              input logic [CODE_W-1:0] rm);
        case (mode)
            MODE_REG:   disp_bytes = 2'd0;
            MODE_MEM8:  disp_bytes = 2'd1;
            MODE_MEM16: disp_bytes = 2'd2;
            default:    disp_bytes = (rm == RM_DIRECT) ? 2'd2 : 2'd0;
        endcase
    endfunction

    function automatic logic [DISP_W-1:0] widen_byte(input logic [BYTE_W-1:0] b);
        widen_byte = {{(DISP_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

endpackage

// File: rtl/movdec_fsm.sv
module movdec_fsm
    import movdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              take_op,
    output logic              take_modrm,
    output logic              take_lo,
    output logic              take_hi,
    output logic              done,
    output logic              bad_op
);

    dec_state_e state_q, state_d;
    logic [1:0] need_q;
    logic [1:0] need_now;

    assign need_now = disp_bytes(in_byte[7:6], in_byte[2:0]);

    always_comb begin
        take_op    = 1'b0;
        take_modrm = 1'b0;
        take_lo    = 1'b0;
        take_hi    = 1'b0;
        done       = 1'b0;
        bad_op     = 1'b0;
        if (in_valid) begin
            case (state_q)
                ST_OPC: begin
                    if (in_byte[7:2] == MOV_RM_OPC) take_op = 1'b1;
                    else                            bad_op  = 1'b1;
                end
                ST_MODRM: begin
                    take_modrm = 1'b1;
                    done       = (need_now == 2'd0);
                end
                ST_DLO: begin
                    take_lo = 1'b1;
                    done    = (need_q == 2'd1);
                end
                default: begin
                    take_hi = 1'b1;
                    done    = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        if (take_op)         state_d = ST_MODRM;
        else if (take_modrm) state_d = done ? ST_OPC : ST_DLO;
        else if (take_lo)    state_d = done ? ST_OPC : ST_DHI;
        else if (take_hi)    state_d = ST_OPC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPC;
            need_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            if (take_modrm) need_q <= need_now;
        end
    end

    AST_HI_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
        take_hi |-> need_q == 2'd2) else $error("high byte without two-byte need"); // R8
    AST_LO_NEEDS_DISP: assert property (@(posedge clk) disable iff (rst)
        take_lo |-> need_q != 2'd0) else $error("displacement byte taken when none needed"); // R5

endmodule

// File: rtl/movdec_fields.sv
module movdec_fields
    import movdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_op,
    input  logic              take_modrm,
    input  logic              take_lo,
    input  logic [BYTE_W-1:0] in_byte,
    output hdr_t              hdr_o,
    output logic [BYTE_W-1:0] lo_o
);

    logic              dir_q, wide_q;
    logic [BYTE_W-1:0] modrm_q, lo_q;
    logic [BYTE_W-1:0] modrm_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= 1'b0;
            wide_q  <= 1'b0;
            modrm_q <= '0;
            lo_q    <= '0;
        end else begin
            if (take_op) begin
                dir_q  <= in_byte[1];
                wide_q <= in_byte[0];
            end
            if (take_modrm) modrm_q <= in_byte;
            if (take_lo)    lo_q    <= in_byte;
        end
    end

    // Merged view: a field arriving this cycle is visible at once.
    assign modrm_v     = take_modrm ? in_byte : modrm_q;
    assign lo_o        = take_lo    ? in_byte : lo_q;
    assign hdr_o.dir   = dir_q;
    assign hdr_o.wide  = wide_q;
    assign hdr_o.mode  = modrm_v[7:6];
    assign hdr_o.reg_f = modrm_v[5:3];
    assign hdr_o.rm_f  = modrm_v[2:0];

endmodule

// File: rtl/movdec_emit.sv
module movdec_emit
    import movdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              bad_op,
    input  hdr_t              hdr,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    output mov_rec_t          rec_q,
    output logic              valid_q,
    output logic              err_q
);

    mov_rec_t rec_d;
    opnd_t    reg_op, rm_op;
    logic     is_direct;

    always_comb begin
        is_direct   = (hdr.mode == MODE_MEM0) && (hdr.rm_f == RM_DIRECT);
        reg_op      = opnd_t'{kind: OPK_REG, code: hdr.reg_f};
        rm_op.kind  = (hdr.mode == MODE_REG) ? OPK_REG : OPK_MEM;
        rm_op.code  = hdr.rm_f;
        rec_d.src   = hdr.dir ? rm_op  : reg_op;
        rec_d.dst   = hdr.dir ? reg_op : rm_op;
        rec_d.wide  = hdr.wide;
        rec_d.direct = is_direct;
        case (hdr.mode)
            MODE_MEM8:  rec_d.disp = widen_byte(lo);
            MODE_MEM16: rec_d.disp = {hi, lo};
            MODE_MEM0:  rec_d.disp = is_direct ? {hi, lo} : '0;
            default:    rec_d.disp = '0;
        endcase
        rec_d.len = BASE_LEN + LEN_W'(disp_bytes(hdr.mode, hdr.rm_f));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= done;
            err_q   <= bad_op;
            if (done) rec_q <= rec_d;
        end
    end

endmodule

// File: rtl/mov_byte_decoder.sv
module mov_byte_decoder
    import movdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic              out_wide,
    output logic              out_src_mem,
    output logic [CODE_W-1:0] out_src_code,
    output logic              out_dst_mem,
    output logic [CODE_W-1:0] out_dst_code,
    output logic              out_direct,
    output logic [DISP_W-1:0] out_disp,
    output logic [LEN_W-1:0]  out_len,
    output logic              err_opcode
);

    logic              take_op, take_modrm, take_lo, take_hi, done, bad_op;
    hdr_t              hdr;
    logic [BYTE_W-1:0] lo;
    mov_rec_t          rec;

    movdec_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .take_op    (take_op),
        .take_modrm (take_modrm),
        .take_lo    (take_lo),
        .take_hi    (take_hi),
        .done       (done),
        .bad_op     (bad_op)
    );

    movdec_fields u_fields (
        .clk        (clk),
        .rst        (rst),
        .take_op    (take_op),
        .take_modrm (take_modrm),
        .take_lo    (take_lo),
        .in_byte    (in_byte),
        .hdr_o      (hdr),
        .lo_o       (lo)
    );

    movdec_emit u_emit (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .bad_op  (bad_op),
        .hdr     (hdr),
        .lo      (lo),
        .hi      (in_byte),
        .rec_q   (rec),
        .valid_q (out_valid),
        .err_q   (err_opcode)
    );

    assign out_wide     = rec.wide;
    assign out_src_mem  = rec.src.kind == OPK_MEM;
    assign out_src_code = rec.src.code;
    assign out_dst_mem  = rec.dst.kind == OPK_MEM;
    assign out_dst_code = rec.dst.code;
    assign out_direct   = rec.direct;
    assign out_disp     = rec.disp;
    assign out_len      = rec.len;

    AST_NO_DOUBLE_EVENT: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && err_opcode)) else $error("record and error together"); // R11
    AST_RECORD_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid) else $error("record held two cycles"); // R11
    AST_ERR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        err_opcode |-> $past(in_valid)) else $error("error without a byte"); // R2
    AST_RECORD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)) else $error("record without a byte"); // R10
    AST_ONE_MEMORY_SIDE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_src_mem && out_dst_mem)) else $error("two memory operands"); // R3
    AST_REG_FORM_SHORT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_src_mem && !out_dst_mem) |-> (out_len == 3'd2 && out_disp == '0))
        else $error("register form with displacement"); // R5
    AST_DIRECT_LONG: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_direct) |-> (out_len == 3'd4 && (out_src_mem || out_dst_mem)))
        else $error("direct form length"); // R9
    AST_SHORT_DISP_SIGNED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == 3'd3) |-> out_disp[15:8] == {8{out_disp[7]}})
        else $error("one-byte displacement not sign-extended"); // R7

endmodule

// File: tb/mov_byte_decoder_test.sv
module mov_byte_decoder_test;

    typedef struct {
        bit          v;
        bit          e;
        bit          wide;
        bit          smem;
        bit [2:0]    scode;
        bit          dmem;
        bit [2:0]    dcode;
        bit          direct;
        bit [15:0]   disp;
        bit [2:0]    len;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid, out_wide, out_src_mem, out_dst_mem, out_direct, err_opcode;
    logic [2:0]  out_src_code, out_dst_code, out_len;
    logic [15:0] out_disp;

    int checks = 0;
    int fails  = 0;
    bit [7:0] pend[$];
    exp_t     expq[$];
    string    cur_tag = "";

    always #5 clk = ~clk;

    mov_byte_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_wide(out_wide),
        .out_src_mem(out_src_mem), .out_src_code(out_src_code),
        .out_dst_mem(out_dst_mem), .out_dst_code(out_dst_code),
        .out_direct(out_direct), .out_disp(out_disp), .out_len(out_len),
        .err_opcode(err_opcode)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Behavioural model: collect bytes, decide length from what is known.
    task automatic model_byte(input bit [7:0] b);
        exp_t x;
        int need;
        bit [1:0] m;
        bit [2:0] r;
        pend.push_back(b);
        if (pend.size() == 1) begin
            if (b[7:2] != 6'b100010) begin
                x = '{default: 0, tag: ""};
                x.e = 1'b1;
                x.tag = {"R2/", cur_tag};
                expq.push_back(x);
                pend.delete();
            end
            return;
        end
        m = pend[1][7:6];
        r = pend[1][2:0];
        need = (m == 2'b11) ? 2 : (m == 2'b01) ? 3 : (m == 2'b10) ? 4 : (r == 3'b110) ? 4 : 2;
        if (pend.size() < need) return;
        x = '{default: 0, tag: ""};
        x.v = 1'b1;
        x.wide = pend[0][0];
        x.direct = (m == 2'b00) && (r == 3'b110);
        x.len = 3'(need);
        if (need == 3)      x.disp = {{8{pend[2][7]}}, pend[2]};
        else if (need == 4) x.disp = {pend[3], pend[2]};
        if (pend[0][1]) begin
            x.dmem = 1'b0; x.dcode = pend[1][5:3];
            x.smem = (m != 2'b11); x.scode = r;
        end else begin
            x.smem = 1'b0; x.scode = pend[1][5:3];
            x.dmem = (m != 2'b11); x.dcode = r;
        end
        if (m == 2'b11)      x.tag = "R5";
        else if (x.direct)   x.tag = "R9";
        else if (m == 2'b01) x.tag = "R7";
        else if (m == 2'b10) x.tag = "R8";
        else                 x.tag = "R6";
        x.tag = {x.tag, "/", cur_tag};
        expq.push_back(x);
        pend.delete();
    endtask

    task automatic send(input bit [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        model_byte(b);
    endtask

    task automatic stall(input int n, input bit [7:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = junk;
            @(posedge clk);
        end
    endtask

    // Reference comparison on every falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            exp_t x;
            if (expq.size() > 0) x = expq.pop_front();
            else begin
                x = '{default: 0, tag: ""};
                x.tag = "R11";
            end
            checks++;
            if (out_valid !== x.v || err_opcode !== x.e ||
                (x.v && ({out_wide, out_src_mem, out_src_code, out_dst_mem, out_dst_code,
                          out_direct, out_disp, out_len} !==
                         {x.wide, x.smem, x.scode, x.dmem, x.dcode, x.direct, x.disp, x.len}))) begin
                fails++;
                $display("FAIL %s: got v=%b e=%b w=%b s=%b/%0d d=%b/%0d dir=%b disp=%h len=%0d, want v=%b e=%b w=%b s=%b/%0d d=%b/%0d dir=%b disp=%h len=%0d",
                    x.tag, out_valid, err_opcode, out_wide, out_src_mem, out_src_code,
                    out_dst_mem, out_dst_code, out_direct, out_disp, out_len,
                    x.v, x.e, x.wide, x.smem, x.scode, x.dmem, x.dcode, x.direct, x.disp, x.len);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got running, want finished");
        summary();
        $finish;
    end

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || err_opcode !== 1'b0) begin
            fails++;
            $display("FAIL R1: got v=%b e=%b, want v=0 e=0", out_valid, err_opcode);
        end
        pend.delete();
        expq.delete();
        rst = 1'b0;
    endtask

    initial begin
        apply_reset();
        cur_tag = "R3"; send(8'h89); send(8'hD9);             // store, both regs
        cur_tag = "R4"; send(8'h88); send(8'hE5);             // byte regs
        cur_tag = "R3"; send(8'h8B); send(8'h17);             // load from [BX]
        cur_tag = "R4"; send(8'h88); send(8'h02);             // byte store to [BP+SI]
        cur_tag = "R7"; send(8'h8A); send(8'h60); send(8'hF6); // negative offset
        cur_tag = "R7"; send(8'h8A); send(8'h60); send(8'h7F); // positive offset
        cur_tag = "R8"; send(8'h89); send(8'h82); send(8'h34); send(8'h12);
        cur_tag = "R9"; send(8'h8B); send(8'h2E); send(8'h05); send(8'h0D);
        cur_tag = "R2"; send(8'h90); send(8'h89); send(8'hD9);
        cur_tag = "R2"; send(8'h8C); send(8'hC6); send(8'hC6);
        cur_tag = "R10";
        send(8'h8B); stall(3, 8'h90); send(8'h96); stall(2, 8'hFF);
        send(8'hAA); stall(1, 8'h00); send(8'h55);
        cur_tag = "R10"; send(8'h8A); stall(4, 8'h44); send(8'hC1);
        stall(3, 8'h8B);
        cur_tag = "R1"; send(8'h8B); send(8'h86);
        apply_reset();
        cur_tag = "R1"; send(8'h89); send(8'hD9);
        cur_tag = "R11"; stall(4, 8'h89);
        summary();
        $finish;
    end

endmodule